// File: doc/BRIEF.md
# Configuration Word Checksum Checker

This block checks the integrity of a block of 16-bit configuration words while they stream past, one word per accepted cycle. The words usually come from a serial non-volatile memory that another block reads. The checker keeps a running sum of the words in a wide accumulator. It treats the word that closes the block as the stored checksum, and it reports pass or fail once per block. No buffering is needed, so the result is ready one cycle after the closing word.

A block closes either on the word marked as last, or on the word at the parameterised final position, whichever comes first. A block passes only when all of the following hold:

- the last marker falls exactly on the final position;
- the full accumulated sum is not zero;
- the low half of the sum matches the stored word.

An all-zero sum is treated as an erased or blank memory and always fails, even though its low bits would match a zero checksum.

Top module: `cfgsum_checker`

## Requirements
- R1: After reset, resultValid and resultPass are low, and the first word accepted starts a new block.
- R2: Every accepted word before the closing word is added, zero-extended, into an accumulator of ACC_W bits (default 32). Carries out of the low 16 bits are kept and are not wrapped.
- R3: The closing word of a block is taken as the stored checksum and is not added to the sum.
- R4: When the full ACC_W-bit sum of the non-closing words is zero, the block fails, even if the stored checksum is zero.
- R5: A block of correct length with a non-zero sum passes exactly when bits 15:0 of the sum equal the stored checksum. resultPass is high only while resultValid is high.
- R6: The accumulator and the word position restart on the first word after a closed block, so blocks may follow each other with no idle cycle between them.
- R7: resultValid pulses high for one cycle, in the cycle after the closing word is accepted. It is never high at any other time.
- R8: When wordLast is asserted on a word before position BLOCK_LEN-1 (counting from 0), the block closes on that word and fails.
- R9: When the word at position BLOCK_LEN-1 arrives without wordLast, it still closes the block as the checksum word, and the block fails.
- R10: Cycles with wordValid low change neither the sum nor the word position, and they produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A word is presented and accepted this cycle |
| wordLast | input | 1 | The presented word closes the block |
| wordData | input | WORD_W | Configuration word or stored checksum |
| resultValid | output | 1 | One-cycle strobe marking a block result |
| resultPass | output | 1 | Block checksum good (valid with resultValid) |

## Verification
The checker is run over a sweep of pseudo-random blocks. Each block carries either its true checksum or one that is off by a small or large amount, which tells a correct low-half comparison apart from an off-by-bit or wrong-width one. Blocks whose sums carry past 16 bits, with a zero checksum, show that the accumulator is wide and that the zero test covers the full sum. A block of all zeros shows that an empty memory is rejected. Blocks that are cut short, blocks that never assert last, idle gaps inside a block, and blocks sent back to back check that framing and restart are handled apart from the arithmetic.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;

  // Strobes passed from the framing control to the datapath each cycle.
  typedef struct packed {
    logic firstWord;  // current word position is 0
    logic addWord;    // accepted word is added to the sum
    logic evaluate;   // accepted word closes the block (stored checksum)
    logic lengthOk;   // closing word carried last at the final position
  } ctlStrobe_t;

endpackage

// File: rtl/cfgsum_ctrl.sv
module cfgsum_ctrl
  import cfgsum_pkg::*;
#(
  parameter int BLOCK_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       wordLast,
  output ctlStrobe_t strb
);

  localparam int IDX_W = (BLOCK_LEN > 2) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

  logic [IDX_W-1:0] wordIdx;
  logic atFinalPos;
  logic closing;

  assign atFinalPos = (wordIdx == LAST_IDX);
  assign closing    = wordValid && (wordLast || atFinalPos);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (closing) begin
      wordIdx <= '0;
    end else if (wordValid) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  always_comb begin
    strb.firstWord = (wordIdx == '0);
    strb.addWord   = wordValid && !closing;
    strb.evaluate  = closing;
    strb.lengthOk  = wordLast && atFinalPos;
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wordIdx <= LAST_IDX); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(wordIdx)); // R10
  AST_CLOSE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.evaluate |=> (wordIdx == '0)); // R6

endmodule

// File: rtl/cfgsum_datapath.sv
module cfgsum_datapath
  import cfgsum_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [WORD_W-1:0] wordData,
  output logic              resultValid,
  output logic              resultPass
);

  localparam int PAD_W = ACC_W - WORD_W;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] sumSoFar;
  logic [ACC_W-1:0] wordWide;
  logic sumNonZero;
  logic lowMatch;

  // Sum of the words accepted before this one in the current block.
  assign sumSoFar    = strb.firstWord ? '0 : accReg;
  assign wordWide    = {{PAD_W{1'b0}}, wordData};
  assign sumNonZero  = |sumSoFar;
  assign lowMatch    = (sumSoFar[WORD_W-1:0] == wordData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (strb.addWord) begin
      accReg <= sumSoFar + wordWide;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultPass  <= 1'b0;
    end else begin
      resultValid <= strb.evaluate;
      resultPass  <= strb.evaluate && strb.lengthOk && sumNonZero && lowMatch;
    end
  end

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    strb.evaluate |=> resultValid); // R7
  AST_RESULT_ONLY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strb.evaluate)); // R7
  AST_ZERO_SUM_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evaluate && (sumSoFar == '0)) |=> !resultPass); // R4
  AST_SHORT_BLOCK_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evaluate && !strb.lengthOk) |=> !resultPass); // R8
  AST_PASS_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resultPass |-> resultValid); // R5
  AST_CHECKSUM_NOT_ADDED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addWord |=> $stable(accReg)); // R3

endmodule

// File: rtl/cfgsum_checker.sv
module cfgsum_checker
  import cfgsum_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ACC_W     = 32,
  parameter int BLOCK_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic              wordLast,
  input  logic [WORD_W-1:0] wordData,
  output logic              resultValid,
  output logic              resultPass
);

  ctlStrobe_t strb;

  cfgsum_ctrl #(
    .BLOCK_LEN(BLOCK_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordValid(wordValid),
    .wordLast (wordLast),
    .strb     (strb)
  );

  cfgsum_datapath #(
    .WORD_W(WORD_W),
    .ACC_W (ACC_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordData   (wordData),
    .resultValid(resultValid),
    .resultPass (resultPass)
  );

endmodule

// File: tb/cfgsum_checker_bench.sv
`timescale 1ns/1ps
module cfgsum_checker_bench;

  localparam int LEN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic wordLast = 1'b0;
  logic [15:0] wordData = '0;
  logic resultValid;
  logic resultPass;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  cfgsum_checker #(.WORD_W(16), .ACC_W(32), .BLOCK_LEN(LEN)) u_cfgsum_checker (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordLast(wordLast),
    .wordData(wordData), .resultValid(resultValid), .resultPass(resultPass)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [15:0] d, input bit l);
    wordValid = 1'b1; wordData = d; wordLast = l;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wordValid = 1'b0; wordLast = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[31:16];
  endfunction

  function automatic bit expPass(input logic [31:0] s, input logic [15:0] c);
    return (s != 0) && (s[15:0] == c);
  endfunction

  // Full-length block; result checked at the negedge after the closing word.
  task automatic fullBlock(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                           input logic [15:0] chk, input string req, input bit gap);
    logic [31:0] s;
    s = {16'h0, a} + {16'h0, b} + {16'h0, c};
    putWord(a, 1'b0);
    if (gap) begin idle(3); check("R10 no result during gap", {31'h0, resultValid}, 0); end
    putWord(b, 1'b0);
    if (gap) idle(2);
    putWord(c, 1'b0);
    putWord(chk, 1'b1);
    check({req, " valid"}, {31'h0, resultValid}, 1);
    check({req, " pass"}, {31'h0, resultPass}, {31'h0, expPass(s, chk)});
  endtask

  initial begin
    idle(1);
    check("R1 reset valid", {31'h0, resultValid}, 0);
    check("R1 reset pass", {31'h0, resultPass}, 0);
    @(negedge clk); rstN = 1'b1;
    idle(1);
    check("R1 no result after reset", {31'h0, resultValid}, 0);

    // R5 good and bad checksums, R7 one-cycle strobe
    fullBlock(16'h0102, 16'h0304, 16'h0506, 16'h090C, "R5 good block", 1'b0);
    idle(1);
    check("R7 strobe one cycle", {31'h0, resultValid}, 0);
    fullBlock(16'h0102, 16'h0304, 16'h0506, 16'h090D, "R5 bad block", 1'b0);
    idle(1);

    // R2 carries beyond 16 bits retained; zero checksum passes with nonzero sum
    fullBlock(16'hFFFF, 16'h0001, 16'h0000, 16'h0000, "R2 carry to 0x10000", 1'b0);
    idle(1);
    fullBlock(16'hFFFF, 16'hFFFF, 16'h0002, 16'h0000, "R2 carry to 0x20000", 1'b0);
    idle(1);
    // R3 checksum not added: sum 0x0003, checksum 3 passes
    fullBlock(16'h0001, 16'h0002, 16'h0000, 16'h0003, "R3 checksum excluded", 1'b0);
    idle(1);
    // R4 all-zero sum fails
    fullBlock(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R4 zero sum", 1'b0);
    check("R4 zero sum rejected", {31'h0, resultPass}, 0);
    idle(1);

    // R10 idle gaps inside a block
    fullBlock(16'h1111, 16'h2222, 16'h3333, 16'h6666, "R10 gapped block", 1'b1);
    idle(1);

    // R8 early last with a matching checksum
    putWord(16'h0042, 1'b0);
    putWord(16'h0042, 1'b1);
    check("R8 early close valid", {31'h0, resultValid}, 1);
    check("R8 early close fails", {31'h0, resultPass}, 0);
    idle(1);
    putWord(16'h0007, 1'b1);
    check("R8 last on first word valid", {31'h0, resultValid}, 1);
    check("R8 last on first word fails", {31'h0, resultPass}, 0);
    idle(1);

    // R9 missing last still closes at final position; R6 next block restarts
    putWord(16'h0010, 1'b0);
    putWord(16'h0020, 1'b0);
    putWord(16'h0030, 1'b0);
    putWord(16'h0060, 1'b0);
    check("R9 forced close valid", {31'h0, resultValid}, 1);
    check("R9 forced close fails", {31'h0, resultPass}, 0);
    fullBlock(16'h0005, 16'h0006, 16'h0007, 16'h0012, "R6 restart after forced close", 1'b0);

    // R6 back-to-back sweep with correct and perturbed checksums
    for (int k = 0; k < 48; k++) begin
      logic [15:0] a, b, c, chk;
      logic [31:0] s;
      a = nextRand(); b = nextRand(); c = nextRand();
      s = {16'h0, a} + {16'h0, b} + {16'h0, c};
      case (k % 4)
        0: chk = s[15:0];
        1: chk = s[15:0] ^ 16'h0001;
        2: chk = s[15:0] ^ 16'h8000;
        default: chk = s[15:0] + 16'h0100;
      endcase
      fullBlock(a, b, c, chk, "R6 back-to-back sweep", 1'b0);
    end
    idle(1);
    check("R7 strobe ends after sweep", {31'h0, resultValid}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule